// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block sits in front of the array of a pipelined synchronous SRAM. On a clock edge where an address strobe is accepted, it takes in a start address and the state of three chip-enable inputs. It then produces the array address for each beat of a four-beat burst. The upper address bits stay frozen at the captured value. A 2-bit beat counter generates the two low bits, and it moves forward only on edges where the burst-advance input is low. A static mode input chooses how the counter maps onto the low bits: a linear order (start plus beat, wrapping modulo four) or an interleaved order (start XOR beat).

There are two active-low strobes. The processor-side strobe is accepted only while the active-low primary enable is asserted. The controller-side strobe is always accepted. If both are accepted on the same edge, the processor strobe wins. The block registers which strobe started the current burst, so the data path can apply its own per-source rules. On every accepted strobe, the decoded chip select is also registered. This lets the enable decode settle in the same cycle as the address capture, so adding more devices in depth costs no extra cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `arr_addr` is 0, `chip_sel` is 0 and `burst_by_ctrl` is 0.
- R2: On an edge with `ads_proc_n`=0 and `en_n`=0, `arr_addr` becomes `addr_in`, the beat count restarts at 0 and `burst_by_ctrl` becomes 0. All of this is visible right after that edge.
- R3: On an edge with `ads_ctrl_n`=0 and the processor strobe not accepted, `arr_addr` becomes `addr_in`, the beat count restarts and `burst_by_ctrl` becomes 1. This happens whatever the value of `en_n`.
- R4: On an edge with `ads_proc_n`=0, `en_n`=1 and `ads_ctrl_n`=1, the processor strobe is ignored. `arr_addr`, `chip_sel` and `burst_by_ctrl` do not change, unless `adv_n`=0 advances the burst.
- R5: When both strobes are 0 and `en_n`=0, the processor strobe takes priority and `burst_by_ctrl` becomes 0.
- R6: With no accepted strobe, the beat count increments on edges with `adv_n`=0. With `adv_n`=1, all outputs hold.
- R7: Between strobes, `arr_addr[15:2]` stays at the captured start address.
- R8: With `order_il`=0, beat k sets `arr_addr[1:0]` to (start[1:0] + k) mod 4.
- R9: With `order_il`=1, beat k sets `arr_addr[1:0]` to start[1:0] XOR k.
- R10: After four advances, the address is back at the start address.
- R11: On each accepted strobe, `chip_sel` is set to 1 when `en_n`=0, `en_hi`=1 and `en_lo_n`=0, and to 0 otherwise. It holds between strobes.
- R12: An accepted strobe in the middle of a burst restarts at beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 16 | Start address presented with a strobe |
| en_n | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Tertiary chip enable, active low |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Static burst order: 1 interleaved, 0 linear |
| arr_addr | output | 16 | Registered array address of the current beat |
| chip_sel | output | 1 | Registered chip select decoded at the last strobe |
| burst_by_ctrl | output | 1 | 1 when the current burst was started by the controller strobe |

## Verification
All state shows at the ports one edge after the input that changes it. A beat counter that is off by one, or that wraps wrongly, puts the wrong low address bits on `arr_addr` on the very next advance. A base register that was captured wrongly, or that drifts, corrupts the upper bits immediately. A wrong strobe-priority or gating decision flips `burst_by_ctrl` or `chip_sel`, or changes the address, on the edge after the strobe. The scoreboard compares every edge, so any single wrong state is caught within one cycle of the moment it arises.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // Which strobe opened the burst now in progress.
  typedef enum logic {
    SRC_PROC = 1'b0,
    SRC_CTRL = 1'b1
  } load_src_e;

endpackage

// File: rtl/bag_strobe_arb.sv
// Decides whether a strobe is accepted on this edge and which one wins.
module bag_strobe_arb
  import bag_pkg::*;
(
  input  logic      ads_proc_n,
  input  logic      ads_ctrl_n,
  input  logic      en_n,
  output logic      load,
  output load_src_e src
);

  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    // The processor strobe is qualified by the primary enable.
    proc_ok = !ads_proc_n && !en_n;
    ctrl_ok = !ads_ctrl_n;
    load    = proc_ok || ctrl_ok;
    src     = proc_ok ? SRC_PROC : SRC_CTRL;
  end

endmodule

// File: rtl/bag_enable_pipe.sv
// Pipelined chip-select register plus the burst source flag.
module bag_enable_pipe
  import bag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  load_src_e src,
  input  logic      en_n,
  input  logic      en_hi,
  input  logic      en_lo_n,
  output logic      chip_sel,
  output logic      by_ctrl
);

  logic sel_dec;

  always_comb sel_dec = !en_n && en_hi && !en_lo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_sel <= 1'b0;
      by_ctrl  <= 1'b0;
    end else if (load) begin
      chip_sel <= sel_dec;
      by_ctrl  <= (src == SRC_CTRL);
    end
  end

endmodule

// File: rtl/bag_burst_ctr.sv
// Holds the captured base address and the beat counter. It also gives the
// next-state values, so the output register can be loaded in the same edge.
module bag_burst_ctr #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base_nxt,
  output logic [CW-1:0] cnt_nxt
);

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    base_nxt = load ? addr_in : base_q;
    if (load)     cnt_nxt = '0;
    else if (adv) cnt_nxt = cnt_q + 1'b1;
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/bag_order_map.sv
// Maps the start low bits and the beat count onto the array low bits.
module bag_order_map #(
  parameter int unsigned CW = 2
) (
  input  logic [CW-1:0] start_lo,
  input  logic [CW-1:0] beat,
  input  logic          interleave,
  output logic [CW-1:0] lo
);

  logic [CW-1:0] lin;
  logic [CW-1:0] ilv;

  always_comb lin = start_lo + beat;

  // The interleaved order is a bitwise XOR, built one bit at a time.
  for (genvar b = 0; b < CW; b++) begin : g_ilv
    always_comb ilv[b] = start_lo[b] ^ beat[b];
  end

  always_comb lo = interleave ? ilv : lin;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          en_n,
  input  logic          en_hi,
  input  logic          en_lo_n,
  input  logic          ads_proc_n,
  input  logic          ads_ctrl_n,
  input  logic          adv_n,
  input  logic          order_il,
  output logic [AW-1:0] arr_addr,
  output logic          chip_sel,
  output logic          burst_by_ctrl
);

  localparam int unsigned UW = AW - CW;

  logic          load;
  load_src_e     src;
  logic [AW-1:0] base_nxt;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] lo_nxt;

  bag_strobe_arb u_arb (
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .en_n       (en_n),
    .load       (load),
    .src        (src)
  );

  bag_enable_pipe u_en (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .src      (src),
    .en_n     (en_n),
    .en_hi    (en_hi),
    .en_lo_n  (en_lo_n),
    .chip_sel (chip_sel),
    .by_ctrl  (burst_by_ctrl)
  );

  bag_burst_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .adv      (!adv_n),
    .addr_in  (addr_in),
    .base_nxt (base_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  bag_order_map #(.CW(CW)) u_map (
    .start_lo   (base_nxt[CW-1:0]),
    .beat       (cnt_nxt),
    .interleave (order_il),
    .lo         (lo_nxt)
  );

  // The output is registered from the next-state values, so the new beat
  // appears right after the edge that causes it.
  always_ff @(posedge clk) begin
    if (rst) arr_addr <= '0;
    else     arr_addr <= {base_nxt[AW-1:CW], lo_nxt};
  end

  if (UW < 1) begin : g_bad_width
    initial $error("burst_addr_gen: AW must exceed CW");
  end

endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_in,
  input logic          en_n,
  input logic          en_hi,
  input logic          en_lo_n,
  input logic          ads_proc_n,
  input logic          ads_ctrl_n,
  input logic          adv_n,
  input logic          order_il,
  input logic [AW-1:0] arr_addr,
  input logic          chip_sel,
  input logic          burst_by_ctrl
);

  logic accept;
  always_comb accept = !ads_ctrl_n || (!ads_proc_n && !en_n);

  // R2
  proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && !en_n) |=> (arr_addr == $past(addr_in)) && !burst_by_ctrl);

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_ctrl_n && !(!ads_proc_n && !en_n)) |=> (arr_addr == $past(addr_in)) && burst_by_ctrl);

  // R4
  proc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && en_n && ads_ctrl_n) |=> $stable(chip_sel) && $stable(burst_by_ctrl));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && adv_n && $stable(order_il)) |=> $stable(arr_addr));

  // R7
  upper_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(arr_addr[AW-1:CW]));

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !adv_n && !order_il && $stable(order_il))
      |=> arr_addr[CW-1:0] == CW'($past(arr_addr[CW-1:0]) + 1'b1));

  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(chip_sel));

  // R11
  sel_load_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> chip_sel == $past(!en_n && en_hi && !en_lo_n));

endmodule

bind burst_addr_gen bag_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .addr_in       (addr_in),
  .en_n          (en_n),
  .en_hi         (en_hi),
  .en_lo_n       (en_lo_n),
  .ads_proc_n    (ads_proc_n),
  .ads_ctrl_n    (ads_ctrl_n),
  .adv_n         (adv_n),
  .order_il      (order_il),
  .arr_addr      (arr_addr),
  .chip_sel      (chip_sel),
  .burst_by_ctrl (burst_by_ctrl)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  typedef struct {
    logic [15:0] addr;
    logic        sel;
    logic        ctrl;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr_in = '0;
  logic        en_n = 1'b1, en_hi = 1'b0, en_lo_n = 1'b1;
  logic        ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1, order_il = 1'b0;
  logic [15:0] arr_addr;
  logic        chip_sel, burst_by_ctrl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t q[$];

  // Independent reference state
  logic [15:0] m_base = '0;
  logic [1:0]  m_cnt  = '0;
  logic        m_sel  = 1'b0;
  logic        m_ctrl = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen uut (
    .clk (clk), .rst (rst), .addr_in (addr_in),
    .en_n (en_n), .en_hi (en_hi), .en_lo_n (en_lo_n),
    .ads_proc_n (ads_proc_n), .ads_ctrl_n (ads_ctrl_n),
    .adv_n (adv_n), .order_il (order_il),
    .arr_addr (arr_addr), .chip_sel (chip_sel), .burst_by_ctrl (burst_by_ctrl)
  );

  function automatic logic [15:0] ref_addr(logic [15:0] b, logic [1:0] k, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[15:2], lo};
  endfunction

  // Driver: applies one edge of stimulus and queues the outcome it predicts.
  task automatic step(input logic pn, input logic cn, input logic av,
                      input logic e0, input logic e1, input logic e2,
                      input logic [15:0] a, input logic il, input string tag);
    exp_t e;
    bit p_ok, c_ok;
    @(negedge clk);
    ads_proc_n = pn; ads_ctrl_n = cn; adv_n = av;
    en_n = e0; en_hi = e1; en_lo_n = e2; addr_in = a; order_il = il;
    p_ok = !pn && !e0;
    c_ok = !cn;
    if (p_ok || c_ok) begin
      m_base = a;
      m_cnt  = 2'd0;
      m_sel  = !e0 && e1 && !e2;
      m_ctrl = !p_ok;
    end else if (!av) begin
      m_cnt = m_cnt + 2'd1;
    end
    e.addr = ref_addr(m_base, m_cnt, il);
    e.sel  = m_sel;
    e.ctrl = m_ctrl;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // Shorthands: advance or hold with no strobe and the enables left at their idle values.
  task automatic adv(input logic il, input string tag);
    step(1, 1, 0, 1, 0, 1, 16'h0000, il, tag);
  endtask

  task automatic idle(input logic il, input string tag);
    step(1, 1, 1, 1, 0, 1, 16'h0000, il, tag);
  endtask

  // Monitor: compares every predicted edge against the outputs.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (arr_addr !== e.addr || chip_sel !== e.sel || burst_by_ctrl !== e.ctrl) begin
        fails++;
        $display("FAIL %s: addr=%h sel=%b ctrl=%b expected addr=%h sel=%b ctrl=%b",
                 e.tag, arr_addr, chip_sel, burst_by_ctrl, e.addr, e.sel, e.ctrl);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    checks++;
    if (arr_addr !== 16'h0 || chip_sel !== 1'b0 || burst_by_ctrl !== 1'b0) begin
      fails++;
      $display("FAIL R1: addr=%h sel=%b ctrl=%b expected addr=0000 sel=0 ctrl=0",
               arr_addr, chip_sel, burst_by_ctrl);
    end
    rst = 1'b0;

    // R2 processor load, then a linear burst (R8) wrapping to the start (R10)
    step(0, 1, 1, 0, 1, 0, 16'h1235, 0, "R2");
    adv(0, "R8");
    idle(0, "R6");
    adv(0, "R8");
    adv(0, "R7");
    adv(0, "R10");
    idle(0, "R6");

    // R3 controller load with the primary enable high, so R11 gives select 0.
    // Then an interleaved burst (R9).
    step(1, 0, 1, 1, 1, 0, 16'hABC6, 1, "R3");
    adv(1, "R9");
    adv(1, "R9");
    adv(1, "R9");
    adv(1, "R10");

    // R4 processor strobe ignored while en_n is high, without and with advance
    step(0, 1, 1, 1, 1, 0, 16'h5555, 1, "R4");
    step(0, 1, 0, 1, 1, 0, 16'h7777, 1, "R4");

    // R5 both strobes with en_n low: the processor wins
    step(0, 0, 1, 0, 1, 0, 16'h00F3, 0, "R5");
    adv(0, "R8");

    // R12 controller strobe mid-burst restarts at the new address
    step(1, 0, 0, 0, 0, 0, 16'h9A01, 0, "R12");
    adv(0, "R12");

    // R11 select decode for several enable patterns
    step(0, 1, 1, 0, 1, 1, 16'h2222, 0, "R11");
    step(1, 0, 1, 0, 1, 0, 16'h3333, 0, "R11");
    idle(0, "R11");
    step(1, 0, 1, 1, 1, 0, 16'h4440, 1, "R11");

    // R9 interleaved burst from low bits 00 and 11
    adv(1, "R9");
    adv(1, "R9");
    step(0, 1, 1, 0, 1, 0, 16'hFFFF, 1, "R2");
    adv(1, "R9");
    adv(1, "R9");
    adv(1, "R9");
    adv(1, "R10");
    idle(1, "R6");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

endmodule